// File: doc/BRIEF.md
# UART Two-Stage Baud Tick Generator

This block derives the timing enables for a UART from a single reference clock. A 16-bit prescale counter turns the reference clock into a sample-rate enable. A second counter then groups a programmable number of those sample enables into one bit period and raises a bit-rate enable. An optional fixed divide-by-8 stage can slow the reference clock before both counters.

The serial shifters use the two outputs as synchronous clock enables. The bit period is `prescale * (field + 1)` reference cycles, multiplied by 8 when the divide-by-8 select is set. A prescale value of zero switches the generator off. The samples-per-bit field is written as the sample count minus one. Field values below 4 leave the previous valid setting in force.

Top module: `uart_baud_gen`

## Requirements
- R1: While `prescale` is 0, `sample_tick` and `bit_tick` stay low and both counters are held at zero.
- R2: With `div8_sel` low and `prescale` = N (1..65535), `sample_tick` is high once every N clock cycles; with N = 1 it is high on every cycle.
- R3: With `div8_sel` high, every sample and bit interval is 8 times the interval it has with `div8_sel` low.
- R4: With a field value F in 4..255, `bit_tick` is high on every (F+1)-th `sample_tick`, and only in a cycle in which `sample_tick` is also high.
- R5: Field values 0..3 are ignored, and the last field value in 4..255 stays in effect. After reset the effective field value is 15, which gives 16 samples per bit.
- R6: Any change of `prescale`, of the effective field value or of `div8_sel` restarts both counters. Counting cycle 0 as the first cycle after the clock edge that sees the change, the first `sample_tick` comes in cycle P-1 and the first `bit_tick` in cycle P*(F+1)-1. Here P is N, or 8N when `div8_sel` is high.
- R7: While `rst_n` is low, both tick outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prescale | input | 16 | Prescale divisor, 0 disables the generator |
| spb_field | input | 8 | Samples per bit minus one, 4..255 valid |
| div8_sel | input | 1 | 1 selects the reference clock divided by 8 |
| sample_tick | output | 1 | Sample-rate enable |
| bit_tick | output | 1 | Bit-rate enable |

## Verification
A corrupted prescale or bit counter shows up at the ports within one bit period, as a wrong distance between ticks. A missed restart shows up as a first tick that comes early, right after a configuration change. The bench measures the position of the first tick and the spacing of the second tick after every change, so a fault appears at the very next tick.

A held field value that was overwritten by an ignored field value appears as a bit spacing of the wrong length. A divide-by-8 stage that is out of phase shifts the first sample tick by up to seven cycles.

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int PRE_W   = 16,
  parameter int SPB_W   = 8,
  parameter int D8_W    = 3,
  parameter int SPB_MIN = 4,
  parameter int SPB_RST = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] prescale,
  input  logic [SPB_W-1:0] spb_field,
  input  logic             div8_sel,
  output logic             sample_tick,
  output logic             bit_tick
);
  localparam int CFG_W = PRE_W + SPB_W + 1;

  logic [D8_W-1:0]  d8_cnt;
  logic [PRE_W-1:0] pre_cnt;
  logic [SPB_W-1:0] bit_cnt, spb_hold, spb_eff;
  logic [CFG_W-1:0] cfg, cfg_q;

  wire field_ok = spb_field >= SPB_W'(SPB_MIN);
  assign spb_eff = field_ok ? spb_field : spb_hold;
  assign cfg     = {prescale, spb_eff, div8_sel};

  wire reload   = cfg != cfg_q;
  wire running  = (prescale != '0) && !reload;
  wire pre_en   = running && (!div8_sel || (&d8_cnt));
  wire pre_wrap = pre_cnt == (prescale - PRE_W'(1));

  assign sample_tick = pre_en && pre_wrap;
  assign bit_tick    = sample_tick && (bit_cnt == spb_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      spb_hold <= SPB_W'(SPB_RST);
      d8_cnt   <= '0;
      pre_cnt  <= '0;
      bit_cnt  <= '0;
    end else begin
      cfg_q <= cfg;
      if (field_ok) spb_hold <= spb_field;
      if (!running) begin
        d8_cnt  <= '0;
        pre_cnt <= '0;
        bit_cnt <= '0;
      end else begin
        if (div8_sel) d8_cnt <= d8_cnt + D8_W'(1);
        if (pre_en)   pre_cnt <= pre_wrap ? '0 : pre_cnt + PRE_W'(1);
        if (sample_tick) bit_cnt <= bit_tick ? '0 : bit_cnt + SPB_W'(1);
      end
    end
  end

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (prescale == '0) |-> (!sample_tick && !bit_tick && pre_cnt == '0 && bit_cnt == '0));
  assert_sample_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prescale != '0) |-> (pre_cnt < prescale));
  assert_bit_with_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);
  assert_bit_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= spb_eff);
  assert_field_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spb_eff >= SPB_W'(SPB_MIN));
  assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prescale != $past(prescale) || div8_sel != $past(div8_sel)) |-> !sample_tick);
  assert_reset_quiet_R7: assert property (@(posedge clk)
    !rst_n |-> (!sample_tick && !bit_tick));
endmodule

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;
  logic clk = 0, rst_n = 0, div8_sel = 0;
  logic [15:0] prescale = 0;
  logic [7:0]  spb_field = 4;
  logic sample_tick, bit_tick;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  uart_baud_gen u_dut (.clk, .rst_n, .prescale, .spb_field, .div8_sel, .sample_tick, .bit_tick);

  localparam int NV = 8;
  localparam int VP [NV] = '{3, 1, 5, 2, 1, 7, 300, 4};
  localparam int VF [NV] = '{4, 4, 7, 4, 9, 15, 4, 255};
  localparam int VD [NV] = '{0, 0, 0, 1, 1, 0, 0, 1};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(int p, int f, int d);
    @(negedge clk);
    prescale = 16'(p); spb_field = 8'(f); div8_sel = d[0];
  endtask

  task automatic measure(int p, int f, int d, bit first, string tag);
    int ps, pb, s0, s1, b0, b1;
    ps = p * (d != 0 ? 8 : 1);
    pb = ps * (f + 1);
    s0 = -1; s1 = -1; b0 = -1; b1 = -1;
    @(posedge clk);
    for (int j = 0; j < 3 * pb + 20 && b1 < 0; j++) begin
      @(negedge clk);
      if (sample_tick) begin if (s0 < 0) s0 = j; else if (s1 < 0) s1 = j; end
      if (bit_tick) begin if (b0 < 0) b0 = j; else b1 = j; end
    end
    if (first) begin
      chk({tag, " R6 first sample"}, s0, ps - 1);
      chk({tag, " R6 first bit"}, b0, pb - 1);
    end
    chk({tag, d != 0 ? " R3 sample period" : " R2 sample period"}, s1 - s0, ps);
    chk({tag, " R4 bit period"}, b1 - b0, pb);
  endtask

  task automatic quiet(int n, string tag);
    int cnt;
    cnt = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (sample_tick || bit_tick) cnt++;
    end
    chk(tag, cnt, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    prescale = 1; spb_field = 4;
    quiet(20, "R7 ticks in reset");
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      drive(VP[i], VF[i], VD[i]);
      measure(VP[i], VF[i], VD[i], 1'b1, $sformatf("vec%0d", i));
    end

    drive(10, 4, 0);
    repeat (23) @(negedge clk);
    drive(6, 4, 0);
    measure(6, 4, 0, 1'b1, "mid-period R6");

    drive(4, 7, 0);
    measure(4, 7, 0, 1'b1, "held field");
    drive(4, 2, 0);
    measure(4, 7, 0, 1'b0, "ignored field R5");

    drive(0, 4, 0);
    quiet(300, "R1 disabled");
    drive(3, 4, 0);
    measure(3, 4, 0, 1'b1, "re-enable R1");

    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    prescale = 2; spb_field = 3; div8_sel = 0;
    @(negedge clk); rst_n = 1;
    measure(2, 15, 0, 1'b0, "reset field R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule